// File: doc/BRIEF.md
# Full-Frame Area Sensor Clock Sequencer with Charge Binning

This block produces the digital drive waveforms for a two-phase full-frame area image sensor: a pair of vertical phases with a transfer gate, a pair of horizontal phases, the summing gate ahead of the sense node, and the reset gate. It also produces clamp and sample strobes for an external correlated double sampler, and a pixel-valid strobe. Level shifting and the analog drivers lie outside the block.

After a start pulse the block latches its frame geometry: the number of output lines, the number of output pixels per line, a vertical bin factor, a horizontal bin factor and, for moving-scene imaging, a line period. In frame mode each output line is built from a programmable number of vertical transfers, with the horizontal register frozen. The horizontal register is then clocked out, and the summing gate can gather several horizontal cells into one output pixel. Vertical and horizontal binning can be used together. In time-delay-integration mode, each line is one vertical transfer followed at once by its horizontal readout, and lines begin at a fixed cadence. While idle, both vertical phases rest low so the sensor integrates.

Top module: `fullframe_clock_seq`

## Requirements
- R1: Out of reset and whenever idle, both vertical phases and the transfer gate are 0; both horizontal phases and the summing gate are 1; reset gate, clamp, sample, pixel-valid, busy and done are 0.
- R2: The transfer gate carries exactly the same waveform as the second vertical phase on every cycle.
- R3: The two vertical phases never change in the same cycle, and the two horizontal phases are never 0 together.
- R4: One vertical transfer lasts four cycles, with the vertical phase pair (first, second) going (1,0), (1,1), (0,1), (0,0). During a vertical transfer both horizontal phases stay at 1. During horizontal readout both vertical phases stay at 0.
- R5: In frame mode (mode input 0), every output line is the vertical bin factor's number of transfers followed by the pixel count times the horizontal bin factor of horizontal periods. Lines follow one another with no gap until the line count is reached.
- R6: One horizontal period lasts four cycles. The first horizontal phase goes 0,1,1,1 and the second goes 1,1,0,1.
- R7: With a horizontal bin factor K, the summing gate stays 1 through the first K−1 periods of each group and follows the second horizontal phase in the last period. With K=1 it equals the second horizontal phase throughout.
- R8: In the last period of each group, the reset gate is 1 in its first cycle, clamp in the second, pixel-valid in the third (the cycle in which the summing gate falls) and sample in the fourth. Otherwise these strobes are 0.
- R9: In time-delay-integration mode (mode input 1), each line is one vertical transfer plus its readout. The block stays busy with idle pins until the line period in cycles has elapsed from the line's first cycle. If the readout is longer than the period, the next line starts at once. No padding follows the last line.
- R10: A line count, pixel count, bin factor or line period of 0 acts as 1. The vertical bin factor has no effect in time-delay-integration mode.
- R11: All mode and size inputs are captured when a start is accepted while idle. A start, or a change of these inputs, during a frame has no effect on the waveforms.
- R12: All pins are registered. If start is sampled high at an idle rising edge, the first transfer cycle and busy appear after the following edge. Done is 1 for exactly one cycle, directly after the last cycle of the last pixel, with busy 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one drive tick per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame when idle |
| tdiMode | input | 1 | 0 frame readout, 1 time-delay integration |
| rowCount | input | ROW_W | Output lines per frame |
| colCount | input | COL_W | Output pixels per line |
| vBin | input | BIN_W | Vertical transfers summed per line |
| hBin | input | BIN_W | Horizontal cells summed per pixel |
| linePeriod | input | LINE_W | Line cadence in cycles for time-delay integration |
| p1V | output | 1 | First vertical phase |
| p2V | output | 1 | Second vertical phase |
| tgOut | output | 1 | Transfer gate |
| p1H | output | 1 | First horizontal phase |
| p2H | output | 1 | Second horizontal phase |
| sgOut | output | 1 | Summing gate |
| rgOut | output | 1 | Sense-node reset gate |
| clampStb | output | 1 | Clamp strobe for the sampler |
| sampleStb | output | 1 | Sample strobe for the sampler |
| pixValid | output | 1 | Pixel charge present at sense node |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle the assertions check the phase-overlap rules and the freezing of one register while the other moves. They also check that the summing gate only drops inside a low of the second horizontal phase, that pixel-valid coincides with the summing-gate fall and is followed by sample, and that done is a single cycle that ends busy. The exact counts can only be shown by the bench's scenarios, which compare every pin against a behavioural model each cycle. These cover transfers per line, periods per pixel group, the line-period padding in time-delay integration, zero-as-one handling and the capture of settings at start.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VERT,
    ST_HORZ,
    ST_PAD,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic       inVert;
    logic       inHorz;
    logic [1:0] tick;
    logic       lastBin;
    logic       active;
    logic       fin;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int BIN_W  = 4,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              tdiMode,
  input  logic [ROW_W-1:0]  rowCount,
  input  logic [COL_W-1:0]  colCount,
  input  logic [BIN_W-1:0]  vBin,
  input  logic [BIN_W-1:0]  hBin,
  input  logic [LINE_W-1:0] linePeriod,
  output seqStrobe_t        strobe
);
  localparam logic [ROW_W-1:0]  ROW_ONE  = ROW_W'(1);
  localparam logic [COL_W-1:0]  COL_ONE  = COL_W'(1);
  localparam logic [BIN_W-1:0]  BIN_ONE  = BIN_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  seqState_t         state;
  logic [1:0]        tick;
  logic [BIN_W-1:0]  vCnt, bCnt;
  logic [COL_W-1:0]  colCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic [LINE_W-1:0] lineCnt, lineNext;

  logic [ROW_W-1:0]  cfgRows;
  logic [COL_W-1:0]  cfgCols;
  logic [BIN_W-1:0]  cfgVBin, cfgHBin;
  logic [LINE_W-1:0] cfgLine;
  logic              cfgTdi;

  logic lastVert, lastBin, lastCol, lastRow;

  assign lineNext = (lineCnt == LINE_MAX) ? lineCnt : lineCnt + LINE_ONE;
  assign lastVert = (vCnt == cfgVBin - BIN_ONE);
  assign lastBin  = (bCnt == cfgHBin - BIN_ONE);
  assign lastCol  = (colCnt == cfgCols - COL_ONE);
  assign lastRow  = (rowCnt == cfgRows - ROW_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tick    <= '0;
      vCnt    <= '0;
      bCnt    <= '0;
      colCnt  <= '0;
      rowCnt  <= '0;
      lineCnt <= '0;
      cfgRows <= ROW_ONE;
      cfgCols <= COL_ONE;
      cfgVBin <= BIN_ONE;
      cfgHBin <= BIN_ONE;
      cfgLine <= LINE_ONE;
      cfgTdi  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfgRows <= (rowCount == '0) ? ROW_ONE : rowCount;
            cfgCols <= (colCount == '0) ? COL_ONE : colCount;
            cfgVBin <= (tdiMode || vBin == '0) ? BIN_ONE : vBin;
            cfgHBin <= (hBin == '0) ? BIN_ONE : hBin;
            cfgLine <= (linePeriod == '0) ? LINE_ONE : linePeriod;
            cfgTdi  <= tdiMode;
            state   <= ST_VERT;
            tick    <= '0;
            vCnt    <= '0;
            rowCnt  <= '0;
            lineCnt <= '0;
          end
        end
        ST_VERT: begin
          tick    <= tick + 2'd1;
          lineCnt <= lineNext;
          if (tick == 2'd3) begin
            if (lastVert) begin
              state  <= ST_HORZ;
              vCnt   <= '0;
              bCnt   <= '0;
              colCnt <= '0;
            end else begin
              vCnt <= vCnt + BIN_ONE;
            end
          end
        end
        ST_HORZ: begin
          tick    <= tick + 2'd1;
          lineCnt <= lineNext;
          if (tick == 2'd3) begin
            if (lastBin) begin
              bCnt <= '0;
              if (lastCol) begin
                if (lastRow) begin
                  state <= ST_FIN;
                end else begin
                  rowCnt <= rowCnt + ROW_ONE;
                  if (cfgTdi && (lineNext < cfgLine)) begin
                    state <= ST_PAD;
                  end else begin
                    state   <= ST_VERT;
                    lineCnt <= '0;
                  end
                end
              end else begin
                colCnt <= colCnt + COL_ONE;
              end
            end else begin
              bCnt <= bCnt + BIN_ONE;
            end
          end
        end
        ST_PAD: begin
          lineCnt <= lineNext;
          if (lineNext >= cfgLine) begin
            state   <= ST_VERT;
            lineCnt <= '0;
            tick    <= '0;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.inVert  = (state == ST_VERT);
    strobe.inHorz  = (state == ST_HORZ);
    strobe.tick    = tick;
    strobe.lastBin = lastBin;
    strobe.active  = (state == ST_VERT) || (state == ST_HORZ) || (state == ST_PAD);
    strobe.fin     = (state == ST_FIN);
  end

  // R5: the pixel counter never runs past the latched pixel count
  p_col_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HORZ) |-> (colCnt < cfgCols));

  // R9: only one vertical transfer per line in time-delay integration
  p_tdi_single_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VERT && cfgTdi) |-> (vCnt == '0));

  // R9: line padding happens only in time-delay integration
  p_pad_only_tdi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAD) |-> cfgTdi);

  // R11: captured settings stay put for the whole frame
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |->
      ($stable(cfgRows) && $stable(cfgCols) && $stable(cfgVBin) &&
       $stable(cfgHBin) && $stable(cfgLine) && $stable(cfgTdi)));
endmodule

// File: rtl/seq_drive.sv
module seq_drive
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       p1V,
  output logic       p2V,
  output logic       tgOut,
  output logic       p1H,
  output logic       p2H,
  output logic       sgOut,
  output logic       rgOut,
  output logic       clampStb,
  output logic       sampleStb,
  output logic       pixValid,
  output logic       busy,
  output logic       done
);
  logic vA, vB, hLow1, hLow2, groupEnd;

  assign vA       = strobe.inVert && !strobe.tick[1];
  assign vB       = strobe.inVert && (strobe.tick == 2'd1 || strobe.tick == 2'd2);
  assign hLow1    = strobe.inHorz && (strobe.tick == 2'd0);
  assign hLow2    = strobe.inHorz && (strobe.tick == 2'd2);
  assign groupEnd = strobe.inHorz && strobe.lastBin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p1V       <= 1'b0;
      p2V       <= 1'b0;
      tgOut     <= 1'b0;
      p1H       <= 1'b1;
      p2H       <= 1'b1;
      sgOut     <= 1'b1;
      rgOut     <= 1'b0;
      clampStb  <= 1'b0;
      sampleStb <= 1'b0;
      pixValid  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      p1V       <= vA;
      p2V       <= vB;
      tgOut     <= vB;
      p1H       <= !hLow1;
      p2H       <= !hLow2;
      sgOut     <= !(groupEnd && strobe.tick == 2'd2);
      rgOut     <= groupEnd && (strobe.tick == 2'd0);
      clampStb  <= groupEnd && (strobe.tick == 2'd1);
      pixValid  <= groupEnd && (strobe.tick == 2'd2);
      sampleStb <= groupEnd && (strobe.tick == 2'd3);
      busy      <= strobe.active;
      done      <= strobe.fin;
    end
  end

  // R3: vertical phases never swap in one step
  p_vert_no_cross_r3: assert property (@(posedge clk) disable iff (!rstN)
    !((p1V != $past(p1V)) && (p2V != $past(p2V))));

  // R3: horizontal phases always overlap high
  p_horz_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (p1H || p2H));

  // R4: horizontal register frozen during a vertical transfer
  p_h_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (p1V || p2V) |-> (p1H && p2H));

  // R4: vertical phases quiet during horizontal readout
  p_v_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!p1H || !p2H) |-> (!p1V && !p2V));

  // R7: summing gate only drops inside a low of the second horizontal phase
  p_sg_inside_p2h_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sgOut |-> !p2H);

  // R8: pixel-valid marks exactly the summing-gate fall
  p_valid_on_sg_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> $fell(sgOut));
  p_sg_fall_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sgOut) |-> pixValid);

  // R8: sample follows pixel-valid
  p_sample_after_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> $past(pixValid));

  // R12: done lasts a single cycle and closes busy
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_busy_end_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/fullframe_clock_seq.sv
module fullframe_clock_seq
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int BIN_W  = 4,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              tdiMode,
  input  logic [ROW_W-1:0]  rowCount,
  input  logic [COL_W-1:0]  colCount,
  input  logic [BIN_W-1:0]  vBin,
  input  logic [BIN_W-1:0]  hBin,
  input  logic [LINE_W-1:0] linePeriod,
  output logic              p1V,
  output logic              p2V,
  output logic              tgOut,
  output logic              p1H,
  output logic              p2H,
  output logic              sgOut,
  output logic              rgOut,
  output logic              clampStb,
  output logic              sampleStb,
  output logic              pixValid,
  output logic              busy,
  output logic              done
);
  seqStrobe_t strobe;

  seq_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BIN_W(BIN_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tdiMode(tdiMode),
    .rowCount(rowCount), .colCount(colCount), .vBin(vBin), .hBin(hBin),
    .linePeriod(linePeriod), .strobe(strobe)
  );

  seq_drive u_drive (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .p1V(p1V), .p2V(p2V), .tgOut(tgOut), .p1H(p1H), .p2H(p2H),
    .sgOut(sgOut), .rgOut(rgOut), .clampStb(clampStb),
    .sampleStb(sampleStb), .pixValid(pixValid), .busy(busy), .done(done)
  );
endmodule

// File: tb/fullframe_clock_seq_tb.sv
module fullframe_clock_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        tdiMode = 1'b0;
  logic [7:0]  rowCount = '0;
  logic [7:0]  colCount = '0;
  logic [3:0]  vBin = '0;
  logic [3:0]  hBin = '0;
  logic [15:0] linePeriod = '0;
  logic p1V, p2V, tgOut, p1H, p2H, sgOut, rgOut, clampStb, sampleStb, pixValid, busy, done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string scen = "R1";
  logic [11:0] q[$];
  logic [11:0] prevAct = 12'b000_111_0000_00;
  localparam logic [11:0] IDLE_V = 12'b000_111_0000_00;

  always #10 clk = ~clk;

  fullframe_clock_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .tdiMode(tdiMode),
    .rowCount(rowCount), .colCount(colCount), .vBin(vBin), .hBin(hBin),
    .linePeriod(linePeriod), .p1V(p1V), .p2V(p2V), .tgOut(tgOut),
    .p1H(p1H), .p2H(p2H), .sgOut(sgOut), .rgOut(rgOut),
    .clampStb(clampStb), .sampleStb(sampleStb), .pixValid(pixValid),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog [%s] got hung expected idle", scen);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(string req, logic [11:0] a, logic [11:0] e);
    compared++;
    if (a !== e) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t got %b expected %b", req, scen, $time, a, e);
    end
  endtask

  task automatic push(bit v1, bit v2, bit h1, bit h2, bit sg, bit rg, bit cl,
                      bit va, bit sa, bit bz, bit dn);
    q.push_back({v1, v2, v2, h1, h2, sg, rg, cl, va, sa, bz, dn});
  endtask

  task automatic tick();
    logic [11:0] act, exp;
    @(negedge clk);
    act = {p1V, p2V, tgOut, p1H, p2H, sgOut, rgOut, clampStb, pixValid, sampleStb, busy, done};
    exp = (q.size() > 0) ? q.pop_front() : IDLE_V;
    chk("R4 vertical", {10'b0, act[11:10]}, {10'b0, exp[11:10]});
    chk("R2 transfer gate", {11'b0, act[9]}, {11'b0, exp[9]});
    chk("R6 horizontal", {10'b0, act[8:7]}, {10'b0, exp[8:7]});
    chk("R7 summing gate", {11'b0, act[6]}, {11'b0, exp[6]});
    chk("R8 strobes", {8'b0, act[5:2]}, {8'b0, exp[5:2]});
    chk("R12 busy/done", {10'b0, act[1:0]}, {10'b0, exp[1:0]});
    // R3: overlap rules observed at the pins
    chk("R3 overlap", {11'b0, (act[8] | act[7]) &
        !((act[11] != prevAct[11]) && (act[10] != prevAct[10]))}, 12'd1);
    prevAct = act;
  endtask

  task automatic plan(int rows, int cols, int vb, int hb, int lp, bit tdi);
    int used;
    if (rows == 0) rows = 1;
    if (cols == 0) cols = 1;
    if (vb == 0 || tdi) vb = 1;
    if (hb == 0) hb = 1;
    if (lp == 0) lp = 1;
    q.push_back(IDLE_V);
    for (int r = 0; r < rows; r++) begin
      used = 0;
      for (int v = 0; v < vb; v++)
        for (int t = 0; t < 4; t++) begin
          push(t < 2, t == 1 || t == 2, 1, 1, 1, 0, 0, 0, 0, 1, 0);
          used++;
        end
      for (int c = 0; c < cols; c++)
        for (int b = 0; b < hb; b++)
          for (int t = 0; t < 4; t++) begin
            bit last = (b == hb - 1);
            bit h2 = (t != 2);
            push(0, 0, t != 0, h2, last ? h2 : 1'b1, last && t == 0,
                 last && t == 1, last && t == 2, last && t == 3, 1, 0);
            used++;
          end
      if (tdi && r < rows - 1)
        while (used < lp) begin
          push(0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0);
          used++;
        end
    end
    q.push_back({IDLE_V[11:2], 2'b01});
  endtask

  task automatic launch(int rows, int cols, int vb, int hb, int lp, bit tdi);
    tdiMode = tdi;
    rowCount = 8'(rows);
    colCount = 8'(cols);
    vBin = 4'(vb);
    hBin = 4'(hb);
    linePeriod = 16'(lp);
    start = 1'b1;
    plan(rows, cols, vb, hb, lp, tdi);
    tick();
    start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
    repeat (3) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    scen = "R1 reset idle";
    repeat (4) tick();

    scen = "R5 plain two-dimensional";
    launch(2, 3, 1, 1, 0, 0);
    drain();

    scen = "R5 line binning";
    launch(2, 2, 3, 1, 0, 0);
    drain();

    scen = "R7 pixel binning";
    launch(1, 2, 1, 3, 0, 0);
    drain();

    scen = "R5 R7 combined binning";
    launch(2, 2, 2, 2, 0, 0);
    drain();

    scen = "R9 tdi padded lines";
    launch(3, 2, 1, 1, 20, 1);
    drain();

    scen = "R9 R10 tdi short period, vBin ignored";
    launch(3, 2, 3, 1, 5, 1);
    drain();

    scen = "R10 zero sizes";
    launch(0, 0, 0, 0, 0, 0);
    drain();

    scen = "R11 start during frame";
    launch(2, 2, 1, 1, 0, 0);
    repeat (6) tick();
    tdiMode = 1'b1;
    rowCount = 8'd5;
    colCount = 8'd7;
    vBin = 4'd3;
    hBin = 4'd2;
    linePeriod = 16'd40;
    start = 1'b1;
    tick();
    start = 1'b0;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule